// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM with a 32-bit word and a depth of 2^AW words. Address, strobes, selects, write controls and write data are captured on the rising clock edge. The read path has no output register, so the word at the captured address is on `dout` during the same cycle that follows the edge. Instead of a bidirectional bus, the block drives `dout` together with a qualifier, `dout_en`, and takes write data on a separate `din` input.

An access begins on one of two address strobes. The processor strobe is honoured only while the chip enable is active, and it always starts a read. The controller strobe is honoured whatever the chip enable does, and it may write. Once an access is open, a cycle with neither strobe accepted either advances a 4-beat burst on the two low address bits or repeats the current word. Chip enable and the selects are ignored during these cycles. The burst follows either a linear order or an interleaved order. A sleep input freezes all state and blanks the outputs.

Top module: `fts_burst_sram`

## Requirements
- R1: After reset, `dout_en` is 0 and no access is open until a strobe opens one.
- R2: The device is selected only when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. An accepted strobe without full selection closes the access, and `dout_en` is 0 in the following cycle.
- R3: `strobe_cpu_n`=0 is accepted only with `ce_n`=0. With `ce_n`=1 and `strobe_ctl_n`=1, that cycle acts as a burst continuation.
- R4: A cycle opened by an accepted processor strobe is a read, even if `strobe_ctl_n` is 0. No byte lane is written in that cycle, whatever `gwe_n`, `bwe_n` and `bw_n` are.
- R5: In a write-capable cycle, the lane mask is chosen as follows. With `gwe_n`=0, all lanes are written. Otherwise, with `bwe_n`=0, lane i is written where `bw_n[i]`=0. Otherwise no lane is written. Lane i is `din[8i+7:8i]`.
- R6: After an edge that opens or continues a read, `dout` holds the array word at that cycle's address.
- R7: With `burst_linear`=1, the low two address bits on beat n are (base+n) mod 4, and the sequence wraps after four beats.
- R8: With `burst_linear`=0, the low two address bits on beat n are base XOR n.
- R9: In a continuation cycle, `adv_n`=1 repeats the current address and `adv_n`=0 advances it. This holds for reads and writes, whatever the levels of `ce_n`, `cs_hi` and `cs_lo_n`.
- R10: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R11: In the cycle after an edge that wrote any lane, `dout_en` is 0.
- R12: While `zz`=1, clock edges are ignored: no state changes, no write occurs, the array is retained and `dout_en` is 0.
- R13: Data written at an edge is returned by any later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | AW | Word address captured on an accepted strobe |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, gated by `ce_n` |
| strobe_ctl_n | input | 1 | Controller address strobe, active low, not gated |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| gwe_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte write gate, active low |
| bw_n | input | DW/8 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| din | input | DW | Write data |
| dout | output | DW | Flow-through read data |
| dout_en | output | 1 | High when `dout` would drive the bus |

## Verification
The assertions watch, on every edge, that a processor-strobe cycle never leaves a write behind, and that a deselect or a write silences the outputs in the next cycle. They also check that `oe_n` high always blanks the outputs, that a held burst keeps its address, that a linear advance steps the low bits by one, and that sleep freezes the burst state. Other behaviours depend on stored contents and are shown only by the bench scenarios, which compare against a behavioural reference memory. These are the true data values, partial-lane merges, interleaved beat order across a wrap, retention through sleep, and the outcome of mixed strobe and select patterns.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;

   localparam int LANE_W = 8;

   typedef enum logic [1:0] {
      OP_IDLE     = 2'd0,
      OP_DESEL    = 2'd1,
      OP_LOAD_RD  = 2'd2,
      OP_LOAD_ANY = 2'd3
   } op_e;

   function automatic logic [1:0] burst_bits(input logic [1:0] base,
                                             input logic [1:0] beat,
                                             input logic       linear);
      return linear ? 2'(base + beat) : (base ^ beat);
   endfunction

endpackage

// File: rtl/fts_sram_decode.sv
module fts_sram_decode
   import fts_sram_pkg::*;
(
   input  logic strobe_cpu_n,
   input  logic strobe_ctl_n,
   input  logic ce_n,
   input  logic cs_hi,
   input  logic cs_lo_n,
   output op_e  op
);

   logic sel;
   assign sel = !ce_n && cs_hi && !cs_lo_n;

   always_comb begin
      if (!strobe_cpu_n && !ce_n)
         op = sel ? OP_LOAD_RD : OP_DESEL;
      else if (!strobe_ctl_n)
         op = sel ? OP_LOAD_ANY : OP_DESEL;
      else
         op = OP_IDLE;
   end

endmodule

// File: rtl/fts_sram_burst.sv
module fts_sram_burst
   import fts_sram_pkg::*;
#(
   parameter int AW = 10
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  op_e           op,
   input  logic          adv_n,
   input  logic          linear,
   input  logic [AW-1:0] addr_in,
   output logic          en_q,
   output logic          en_nxt,
   output logic [AW-1:0] eff_cur,
   output logic [AW-1:0] eff_nxt
);

   logic [AW-1:0] base_q, base_nxt;
   logic [1:0]    cnt_q, cnt_nxt;

   always_comb begin
      base_nxt = base_q;
      cnt_nxt  = cnt_q;
      en_nxt   = en_q;
      unique case (op)
         OP_LOAD_RD, OP_LOAD_ANY: begin
            base_nxt = addr_in;
            cnt_nxt  = 2'd0;
            en_nxt   = 1'b1;
         end
         OP_DESEL: en_nxt = 1'b0;
         default: if (en_q && !adv_n) cnt_nxt = cnt_q + 2'd1;
      endcase
   end

   assign eff_cur = {base_q[AW-1:2], burst_bits(base_q[1:0], cnt_q, linear)};
   assign eff_nxt = {base_nxt[AW-1:2], burst_bits(base_nxt[1:0], cnt_nxt, linear)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         en_q   <= 1'b0;
      end else if (run) begin
         base_q <= base_nxt;
         cnt_q  <= cnt_nxt;
         en_q   <= en_nxt;
      end
   end

   // R9
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_IDLE && adv_n) |=> (linear != $past(linear)) || $stable(eff_cur));

   // R7
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_IDLE && !adv_n && en_q && linear)
      |=> !linear || (eff_cur[1:0] == 2'($past(eff_cur[1:0]) + 2'd1)));

   // R12
   sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(en_q) && $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/fts_sram_array.sv
module fts_sram_array
   import fts_sram_pkg::*;
#(
   parameter int AW = 10,
   parameter int NB = 4
)(
   input  logic                 clk,
   input  logic [NB-1:0]        we,
   input  logic [AW-1:0]        waddr,
   input  logic [NB*LANE_W-1:0] wdata,
   input  logic [AW-1:0]        raddr,
   output logic [NB*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[i]) mem[waddr] <= wdata[LANE_W*i +: LANE_W];
      end

      assign rdata[LANE_W*i +: LANE_W] = mem[raddr];
   end

endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
   import fts_sram_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      addr,
   input  logic               strobe_cpu_n,
   input  logic               strobe_ctl_n,
   input  logic               adv_n,
   input  logic               ce_n,
   input  logic               cs_hi,
   input  logic               cs_lo_n,
   input  logic               gwe_n,
   input  logic               bwe_n,
   input  logic [DW/8-1:0]    bw_n,
   input  logic               oe_n,
   input  logic               zz,
   input  logic               burst_linear,
   input  logic [DW-1:0]      din,
   output logic [DW-1:0]      dout,
   output logic               dout_en
);

   localparam int NB = DW / LANE_W;

   if (AW < 3) begin : g_bad_aw
      $error("fts_burst_sram: AW must be at least 3");
   end
   if (DW % LANE_W != 0 || DW < LANE_W) begin : g_bad_dw
      $error("fts_burst_sram: DW must be a nonzero multiple of 8");
   end

   op_e           op;
   logic          run;
   logic          en_q, en_nxt;
   logic [AW-1:0] eff_cur, eff_nxt;
   logic [NB-1:0] req_mask, we;
   logic          wr_ok, wr_q;

   assign run = !zz;

   fts_sram_decode u_dec (
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .ce_n         (ce_n),
      .cs_hi        (cs_hi),
      .cs_lo_n      (cs_lo_n),
      .op           (op)
   );

   fts_sram_burst #(.AW(AW)) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .op      (op),
      .adv_n   (adv_n),
      .linear  (burst_linear),
      .addr_in (addr),
      .en_q    (en_q),
      .en_nxt  (en_nxt),
      .eff_cur (eff_cur),
      .eff_nxt (eff_nxt)
   );

   always_comb begin
      if (!gwe_n)      req_mask = '1;
      else if (!bwe_n) req_mask = ~bw_n;
      else             req_mask = '0;
   end

   assign wr_ok = run && en_nxt && (op != OP_LOAD_RD);
   assign we    = wr_ok ? req_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wr_q <= 1'b0;
      else if (run) wr_q <= |we;
   end

   fts_sram_array #(.AW(AW), .NB(NB)) u_array (
      .clk   (clk),
      .we    (we),
      .waddr (eff_nxt),
      .wdata (din),
      .raddr (eff_cur),
      .rdata (dout)
   );

   assign dout_en = en_q && !wr_q && !oe_n && !zz;

   // R4
   cpu_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !strobe_cpu_n && !ce_n) |=> !wr_q);

   // R2
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_DESEL) |=> !dout_en);

   // R11
   write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|we) |=> !dout_en);

   // R10
   oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

   // R5
   global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op == OP_LOAD_ANY && !gwe_n) |=> wr_q);

endmodule

// File: tb/fts_burst_sram_test.sv
module fts_burst_sram_test;

   localparam int AW    = 6;
   localparam int DW    = 32;
   localparam int NB    = DW / 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic          strobe_cpu_n, strobe_ctl_n, adv_n, ce_n, cs_hi, cs_lo_n;
   logic          gwe_n, bwe_n, oe_n, zz, burst_linear;
   logic [NB-1:0] bw_n;
   logic [DW-1:0] din, dout;
   logic          dout_en;

   always #2 clk = !clk;

   fts_burst_sram #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
      .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
      .gwe_n(gwe_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
      .burst_linear(burst_linear), .din(din), .dout(dout), .dout_en(dout_en)
   );

   logic [DW-1:0] ref_mem [DEPTH];
   bit            ref_ok  [DEPTH];
   int            ref_base, ref_cnt;
   bit            ref_en, ref_wr;
   int            n_chk = 0, n_fail = 0;
   bit            done = 0;

   function automatic int ref_addr(int base, int cnt);
      int low;
      low = burst_linear ? ((base % 4) + cnt) % 4 : ((base % 4) ^ cnt);
      return (base & ~3) | low;
   endfunction

   task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Behavioural prediction of one clock edge from the current inputs
   task automatic model_edge();
      bit sel, p_go, c_go, may_write;
      logic [NB-1:0] mask;
      int a;
      if (zz) return;
      sel  = !ce_n && cs_hi && !cs_lo_n;
      p_go = !strobe_cpu_n && !ce_n;
      c_go = !strobe_ctl_n;
      may_write = 1;
      if (p_go || c_go) begin
         if (sel) begin
            ref_base = addr; ref_cnt = 0; ref_en = 1;
            may_write = !p_go;
         end else ref_en = 0;
      end else if (ref_en && !adv_n) ref_cnt = (ref_cnt + 1) % 4;
      mask = !gwe_n ? '1 : (!bwe_n ? ~bw_n : '0);
      ref_wr = 0;
      if (ref_en && may_write && mask != 0) begin
         a = ref_addr(ref_base, ref_cnt);
         for (int i = 0; i < NB; i++)
            if (mask[i]) ref_mem[a][8*i +: 8] = din[8*i +: 8];
         ref_ok[a] = 1;
         ref_wr = 1;
      end
   endtask

   task automatic tick(string tag);
      bit exp_en;
      int a;
      model_edge();
      @(posedge clk);
      #1;
      exp_en = ref_en && !ref_wr && !oe_n && !zz;
      chk(tag, "dout_en", dout_en, exp_en);
      a = ref_addr(ref_base, ref_cnt);
      if (exp_en && ref_ok[a]) chk(tag, "dout", dout, ref_mem[a]);
   endtask

   task automatic idle();
      strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
      ce_n = 0; cs_hi = 1; cs_lo_n = 0;
      gwe_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; zz = 0;
   endtask

   task automatic ctl_op(int a, string tag);
      idle(); strobe_ctl_n = 0; addr = AW'(a); tick(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_ok[i] = 0;
      ref_base = 0; ref_cnt = 0; ref_en = 0; ref_wr = 0;
      idle(); addr = '0; din = '0; burst_linear = 1;
      #9 rst_n = 1;
      @(posedge clk); #1;
      // R1: reset leaves outputs off
      chk("R1", "dout_en after reset", dout_en, 1'b0);
      adv_n = 0; tick("R1");

      // R5 / R13: global writes fill the array, then R6 reads back
      for (int a = 0; a < DEPTH; a++) begin
         idle(); strobe_ctl_n = 0; addr = AW'(a); gwe_n = 0;
         din = 32'hA500_0000 + 32'(a * 32'h0101_0003); tick("R5");
      end
      for (int a = 0; a < DEPTH; a++) ctl_op(a, "R6");

      // R5: byte writes by lane select, then no-lane write
      idle(); strobe_ctl_n = 0; addr = 6'd5; bwe_n = 0; bw_n = 4'b1010;
      din = 32'h1122_3344; tick("R5");
      ctl_op(5, "R5");
      idle(); strobe_ctl_n = 0; addr = 6'd6; bwe_n = 1; bw_n = 4'b0000;
      din = 32'hDEAD_BEEF; tick("R5");
      ctl_op(6, "R5");

      // R11: write cycle blanks outputs even with oe low
      idle(); strobe_ctl_n = 0; addr = 6'd7; gwe_n = 0; din = 32'h0BAD_F00D; tick("R11");
      chk("R11", "dout_en in write", dout_en, 1'b0);
      ctl_op(7, "R13");

      // R4: processor strobe blocks writes even with ctl strobe low
      idle(); strobe_cpu_n = 0; strobe_ctl_n = 0; addr = 6'd9; gwe_n = 0;
      din = 32'hFFFF_FFFF; tick("R4");
      chk("R4", "dout_en on cpu read", dout_en, 1'b1);
      ctl_op(9, "R4");

      // R7: linear burst from base 1, five beats to see the wrap
      burst_linear = 1;
      ctl_op(13, "R7");
      for (int n = 0; n < 5; n++) begin idle(); adv_n = 0; tick("R7"); end

      // R8: interleaved burst from base 2 and 3
      burst_linear = 0;
      ctl_op(18, "R8");
      for (int n = 0; n < 4; n++) begin idle(); adv_n = 0; tick("R8"); end
      ctl_op(23, "R8");
      for (int n = 0; n < 4; n++) begin idle(); adv_n = 0; tick("R8"); end

      // R9: hold with adv high, continuation ignores chip enable and selects
      burst_linear = 1;
      ctl_op(33, "R9");
      idle(); adv_n = 1; ce_n = 1; tick("R9");
      idle(); adv_n = 0; ce_n = 1; cs_hi = 0; tick("R9");
      idle(); adv_n = 1; cs_lo_n = 1; tick("R9");
      // R9: burst write with a suspended beat
      idle(); strobe_ctl_n = 0; addr = 6'd40; gwe_n = 0; din = 32'h4000_0001; tick("R9");
      idle(); adv_n = 0; gwe_n = 0; din = 32'h4000_0002; tick("R9");
      idle(); adv_n = 1; gwe_n = 0; din = 32'h4000_0003; tick("R9");
      idle(); adv_n = 0; ce_n = 1; gwe_n = 0; din = 32'h4000_0004; tick("R9");
      for (int a = 40; a < 44; a++) ctl_op(a, "R13");

      // R3: cpu strobe with ce high acts as continuation
      ctl_op(48, "R3");
      idle(); strobe_cpu_n = 0; ce_n = 1; adv_n = 0; addr = 6'd2; tick("R3");
      chk("R3", "dout is next beat", dout, ref_mem[49]);

      // R2: deselects from each select input
      ctl_op(50, "R2");
      idle(); strobe_ctl_n = 0; cs_hi = 0; addr = 6'd51; tick("R2");
      ctl_op(50, "R2");
      idle(); strobe_ctl_n = 0; cs_lo_n = 1; tick("R2");
      ctl_op(50, "R2");
      idle(); strobe_ctl_n = 0; ce_n = 1; tick("R2");
      idle(); adv_n = 0; gwe_n = 0; din = 32'h0; tick("R2");
      ctl_op(50, "R2");

      // R10: oe high blanks output with no clock edge
      ctl_op(12, "R10");
      oe_n = 1; #0.5;
      chk("R10", "dout_en async off", dout_en, 1'b0);
      oe_n = 0; #0.5;
      chk("R10", "dout_en async on", dout_en, 1'b1);

      // R12: sleep freezes burst and blocks writes
      ctl_op(20, "R12");
      idle(); zz = 1; adv_n = 0; tick("R12");
      idle(); zz = 1; strobe_ctl_n = 0; addr = 6'd21; gwe_n = 0; din = 32'h5555_AAAA; tick("R12");
      idle(); adv_n = 0; tick("R12");
      ctl_op(21, "R12");

      // R13: mixed random traffic against the reference
      for (int n = 0; n < 3000; n++) begin
         strobe_cpu_n = ($urandom % 100) >= 15;
         strobe_ctl_n = ($urandom % 100) >= 20;
         ce_n    = ($urandom % 100) >= 85;
         cs_hi   = ($urandom % 100) < 93;
         cs_lo_n = ($urandom % 100) >= 93;
         adv_n   = ($urandom % 100) >= 60;
         gwe_n   = ($urandom % 100) >= 15;
         bwe_n   = ($urandom % 100) >= 25;
         bw_n    = NB'($urandom);
         oe_n    = ($urandom % 100) >= 85;
         zz      = ($urandom % 100) < 3;
         addr    = AW'($urandom);
         din     = $urandom;
         if (n % 100 == 0) burst_linear = $urandom % 2;
         tick("R13");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule